// File: doc/BRIEF.md
# SWD Host Register Transaction Engine

This block is the host side of a two-wire serial debug link. It carries out one register access per request: it builds an 8-bit request header with computed parity, shifts it out on the data line, hands the line to the target for a turnaround, and collects a 3-bit acknowledge. When the acknowledge is OK, it moves a 32-bit data word with an even parity bit. For a read the target drives the word. For a write the host drives it. The block then reports a status code, plus the read word for reads.

An internal divider produces the serial clock from the system clock. Each serial clock half-period is `div + 1` system clock cycles. The serial clock runs only while a transaction is active and sits low otherwise. A divider update that slows the link takes effect at once. An update that speeds the link is held until the link is idle, so a transaction never speeds up midway. Retry policy and any queueing stay with the caller.

Top module: `swd_xact_engine`

## Requirements
- R1: The header goes out least significant bit first. Bit 0 = 1 (start). Bit 1 = access-port select. Bit 2 = read flag. Bits 4:3 = `req_addr[1:0]`. Bit 5 = even parity of bits 1..4. Bit 6 = 0. Bit 7 = 1.
- R2: The host releases the line (`swdio_oe` = 0) for the single turnaround slot after the header and for the three acknowledge slots.
- R3: The acknowledge is received LSB first, with OK = 3'b001, WAIT = 3'b010 and FAULT = 3'b100. WAIT ends the access with status 1, FAULT with status 2, and any other code with status 3. Each of these ends after one released turnaround slot, with no data phase.
- R4: On an OK read, 32 data bits (LSB first) and a parity bit are sampled, followed by one released turnaround slot. `rdata` carries the word. Status is 0, or 4 when the parity bit does not give even parity over the 33 bits.
- R5: On an OK write, one released turnaround slot comes first. The host then drives 32 data bits LSB first, followed by their even parity bit, and ends with status 0.
- R6: The host changes `swdio_out` and `swdio_oe` only when `swclk` falls. It samples `swdio_in` when `swclk` rises.
- R7: Each `swclk` half-period lasts `div + 1` clock cycles. A `div` update that is greater than or equal to the current value applies at once. A smaller value is held until the block is idle.
- R8: `done` pulses for one cycle at the end of an access, with `status` valid in that cycle. While `busy` is high, `req_valid` is ignored.
- R9: After reset and while idle, `busy` = 0, `swclk` = 0, `done` = 0, and the host drives the line low (`swdio_oe` = 1, `swdio_out` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an access (accepted when idle) |
| req_ap | input | 1 | 1 = access-port register, 0 = debug-port register |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | 32 | Write data |
| div_valid | input | 1 | Divider update strobe |
| div_val | input | DIV_W | New half-period value minus one |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| status | output | 3 | 0 OK, 1 WAIT, 2 FAULT, 3 protocol error, 4 parity error |
| rdata | output | 32 | Read data word |
| swclk | output | 1 | Serial clock |
| swdio_out | output | 1 | Serial data driven by the host |
| swdio_oe | output | 1 | Host drive enable for the serial data line |
| swdio_in | input | 1 | Serial data seen on the line |

## Verification
A divider update can arrive in the same cycle as an active transaction's slot timing. The bench provokes this by pulsing a faster setting and, later, a slower setting partway through accesses. It judges the outcome from the measured `swclk` half-periods: the faster value must not show until the next access, and the slower value must show within the same access. A second request can also land during an active access. The bench sends one mid-header and checks that the header in flight is unchanged and that no new access starts after `done`.

// File: rtl/swd_pkg.sv
package swd_pkg;

    localparam int HDR_W  = 8;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_OK     = 3'd0,
        ST_WAIT   = 3'd1,
        ST_FAULT  = 3'd2,
        ST_PROTO  = 3'd3,
        ST_PARERR = 3'd4
    } status_e;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_TRN1, S_ACK, S_RDATA, S_TRN2, S_WDATA
    } phase_e;

    typedef struct packed {
        logic              ap;
        logic              rd;
        logic [1:0]        addr;
        logic [WORD_W-1:0] wdata;
    } req_t;

    // Header as sent on the wire, bit 0 first.
    function automatic logic [HDR_W-1:0] build_hdr(input req_t r);
        logic par;
        par = r.ap ^ r.rd ^ r.addr[1] ^ r.addr[0];
        return {1'b1, 1'b0, par, r.addr[1], r.addr[0], r.rd, r.ap, 1'b1};
    endfunction

endpackage

// File: rtl/swd_clk_div.sv
module swd_clk_div #(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             set_valid,
    input  logic [DIV_W-1:0] set_val,
    output logic             swclk,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] div_cur;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] pend_val;
    logic             pend_valid;
    logic             tick;

    assign tick = en && (cnt >= div_cur);
    assign rise = tick && !swclk;
    assign fall = tick && swclk;

    // Slower settings apply at once; faster ones wait for idle.
    always_ff @(posedge clk) begin
        if (rst) begin
            div_cur    <= DIV_W'(DIV_RST);
            pend_val   <= '0;
            pend_valid <= 1'b0;
        end else if (set_valid) begin
            if (set_val >= div_cur) begin
                div_cur    <= set_val;
                pend_valid <= 1'b0;
            end else begin
                pend_val   <= set_val;
                pend_valid <= 1'b1;
            end
        end else if (pend_valid && !en) begin
            div_cur    <= pend_val;
            pend_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt   <= '0;
            swclk <= 1'b0;
        end else if (tick) begin
            cnt   <= '0;
            swclk <= !swclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/swd_seq.sv
module swd_seq
    import swd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  req_t              req,
    input  logic              rise,
    input  logic              fall,
    input  logic              swdio_in,
    output logic              busy,
    output logic              done,
    output status_e           status,
    output logic [WORD_W-1:0] rdata,
    output logic              swdio_out,
    output logic              swdio_oe
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_HDR  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_ACK  = CNT_W'(2);
    localparam logic [CNT_W-1:0] PAR_SLOT  = CNT_W'(WORD_W);

    phase_e            st;
    logic [CNT_W-1:0]  bcnt;
    logic [HDR_W-1:0]  hdr_q;
    logic [WORD_W-1:0] wsh, rsh;
    logic              wpar, racc, perr, is_rd, go_wr;
    logic [2:0]        ack_q;

    assign busy     = (st != S_IDLE);
    assign swdio_oe = (st == S_IDLE) || (st == S_HDR) || (st == S_WDATA);
    always_comb begin
        unique case (st)
            S_HDR:   swdio_out = hdr_q[0];
            S_WDATA: swdio_out = (bcnt == PAR_SLOT) ? wpar : wsh[0];
            default: swdio_out = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            st     <= S_IDLE;
            bcnt   <= '0;
            hdr_q  <= '0;
            wsh    <= '0;
            rsh    <= '0;
            rdata  <= '0;
            wpar   <= 1'b0;
            racc   <= 1'b0;
            perr   <= 1'b0;
            is_rd  <= 1'b0;
            go_wr  <= 1'b0;
            ack_q  <= '0;
            status <= ST_OK;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    st    <= S_HDR;
                    hdr_q <= build_hdr(req);
                    wsh   <= req.wdata;
                    wpar  <= ^req.wdata;
                    is_rd <= req.rd;
                    bcnt  <= '0;
                    go_wr <= 1'b0;
                end
                S_HDR: if (fall) begin
                    if (bcnt == LAST_HDR) begin
                        st   <= S_TRN1;
                        bcnt <= '0;
                    end else begin
                        bcnt  <= bcnt + 1'b1;
                        hdr_q <= {1'b0, hdr_q[HDR_W-1:1]};
                    end
                end
                S_TRN1: if (fall) st <= S_ACK;
                S_ACK: begin
                    if (rise) ack_q <= {swdio_in, ack_q[2:1]};
                    if (fall) begin
                        if (bcnt == LAST_ACK) begin
                            bcnt <= '0;
                            st   <= S_TRN2;
                            unique case (ack_q)
                                ACK_OK: begin
                                    status <= ST_OK;
                                    racc   <= 1'b0;
                                    if (is_rd) st <= S_RDATA;
                                    else       go_wr <= 1'b1;
                                end
                                ACK_WAIT:  status <= ST_WAIT;
                                ACK_FAULT: status <= ST_FAULT;
                                default:   status <= ST_PROTO;
                            endcase
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                end
                S_RDATA: begin
                    if (rise) begin
                        if (bcnt != PAR_SLOT) begin
                            rsh  <= {swdio_in, rsh[WORD_W-1:1]};
                            racc <= racc ^ swdio_in;
                        end else begin
                            perr <= racc ^ swdio_in;
                        end
                    end
                    if (fall) begin
                        if (bcnt == PAR_SLOT) begin
                            st     <= S_TRN2;
                            rdata  <= rsh;
                            status <= perr ? ST_PARERR : ST_OK;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                end
                S_TRN2: if (fall) begin
                    if (go_wr) begin
                        st    <= S_WDATA;
                        bcnt  <= '0;
                        go_wr <= 1'b0;
                    end else begin
                        st   <= S_IDLE;
                        done <= 1'b1;
                    end
                end
                S_WDATA: if (fall) begin
                    if (bcnt == PAR_SLOT) begin
                        st   <= S_IDLE;
                        done <= 1'b1;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                        wsh  <= {1'b0, wsh[WORD_W-1:1]};
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/swd_xact_engine.sv
module swd_xact_engine
    import swd_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_ap,
    input  logic              req_rd,
    input  logic [1:0]        req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              div_valid,
    input  logic [DIV_W-1:0]  div_val,
    output logic              busy,
    output logic              done,
    output logic [2:0]        status,
    output logic [WORD_W-1:0] rdata,
    output logic              swclk,
    output logic              swdio_out,
    output logic              swdio_oe,
    input  logic              swdio_in
);
    req_t    req;
    status_e st_e;
    logic    rise, fall, start;

    assign req    = '{ap: req_ap, rd: req_rd, addr: req_addr, wdata: req_wdata};
    assign start  = req_valid && !busy;
    assign status = st_e;

    swd_clk_div #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) div_i (
        .clk(clk), .rst(rst), .en(busy),
        .set_valid(div_valid), .set_val(div_val),
        .swclk(swclk), .rise(rise), .fall(fall)
    );

    swd_seq seq_i (
        .clk(clk), .rst(rst), .start(start), .req(req),
        .rise(rise), .fall(fall), .swdio_in(swdio_in),
        .busy(busy), .done(done), .status(st_e), .rdata(rdata),
        .swdio_out(swdio_out), .swdio_oe(swdio_oe)
    );
endmodule

// File: rtl/swd_xact_engine_chk.sv
module swd_xact_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic [2:0] status,
    input logic       swclk,
    input logic       swdio_out,
    input logic       swdio_oe
);
    // R6: line outputs hold while swclk stays high
    assert_hold_high_R6: assert property (@(posedge clk) disable iff (rst)
        (swclk && $past(swclk)) |-> ($stable(swdio_out) && $stable(swdio_oe)));

    // R6: outputs can only move in a cycle where swclk just fell or the block was idle
    assert_change_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy && !$stable(swdio_oe)) |-> $fell(swclk));

    // R8: done lasts exactly one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done marks the end of busy
    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R3: reported status is a defined code
    assert_status_code_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (status <= 3'd4));

    // R9: idle keeps the clock low and drives the line low
    assert_idle_line_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!swclk && swdio_oe && !swdio_out));
endmodule

bind swd_xact_engine swd_xact_engine_chk chk_i (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .status(status),
    .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe)
);

// File: tb/swd_xact_engine_tb_top.sv
`timescale 1ns/1ps
module swd_xact_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_ap = 1'b0, req_rd = 1'b0;
    logic [1:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        div_valid = 1'b0;
    logic [7:0]  div_val = '0;
    logic        swdio_in = 1'b1;
    logic        busy, done, swclk, swdio_out, swdio_oe;
    logic [2:0]  status;
    logic [31:0] rdata;

    int checks = 0, errors = 0;
    int run_c = 0, last_half = 0;
    logic swclk_prev = 1'b0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    swd_xact_engine dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ap(req_ap),
        .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
        .div_valid(div_valid), .div_val(div_val), .busy(busy), .done(done),
        .status(status), .rdata(rdata), .swclk(swclk), .swdio_out(swdio_out),
        .swdio_oe(swdio_oe), .swdio_in(swdio_in)
    );

    // half-period monitor in clk cycles
    always @(posedge clk) begin
        if (swclk !== swclk_prev) begin
            last_half <= run_c;
            run_c     <= 1;
        end else begin
            run_c <= run_c + 1;
        end
        swclk_prev <= swclk;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic ap, input logic rd, input logic [1:0] a, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_ap = ap; req_rd = rd; req_addr = a; req_wdata = wd;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic slot(input bit drv, input logic v, output logic o, output logic oe);
        #1 swdio_in = drv ? v : 1'b1;
        @(posedge swclk); #1;
        o = swdio_out; oe = swdio_oe;
        @(negedge swclk);
    endtask

    function automatic logic [7:0] exp_hdr(input logic ap, input logic rd, input logic [1:0] a);
        logic p;
        p = ap ^ rd ^ a[0] ^ a[1];
        exp_hdr = 8'b1000_0001 | (8'(ap) << 1) | (8'(rd) << 2) | (8'(a) << 3) | (8'(p) << 5);
    endfunction

    // fields: ap, rd, addr, ack, badpar, data, expected status
    localparam int NV = 8;
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 1'b1, 2'd0, 3'b001, 1'b0, 32'h2BA0_1477, 3'd0},
        {1'b1, 1'b0, 2'd1, 3'b001, 1'b0, 32'hA5A5_0F0F, 3'd0},
        {1'b1, 1'b1, 2'd3, 3'b001, 1'b1, 32'h8000_0001, 3'd4},
        {1'b0, 1'b0, 2'd2, 3'b010, 1'b0, 32'h1234_5678, 3'd1},
        {1'b1, 1'b1, 2'd2, 3'b100, 1'b0, 32'h0000_0000, 3'd2},
        {1'b0, 1'b1, 2'd1, 3'b111, 1'b0, 32'h0000_0000, 3'd3},
        {1'b0, 1'b0, 2'd3, 3'b000, 1'b0, 32'hFFFF_FFFF, 3'd3},
        {1'b1, 1'b0, 2'd0, 3'b001, 1'b0, 32'hFFFF_FFFF, 3'd0}
    };

    task automatic xact(input logic [42:0] v, input bit poke);
        logic ap, rd, bp, o, oe, all_oe, rel;
        logic [1:0] a;
        logic [2:0] ack, est;
        logic [31:0] d, got;
        logic [7:0] hdr;
        logic gp;
        {ap, rd, a, ack, bp, d, est} = v;
        issue(ap, rd, a, d);
        all_oe = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (poke && i == 2) begin
                // R8: second request during the header is ignored
                req_valid = 1'b1; req_ap = ~ap; req_rd = ~rd; req_addr = ~a;
                @(posedge clk); #1 req_valid = 1'b0;
            end
            slot(1'b0, 1'b0, o, oe);
            hdr[i] = o; all_oe &= oe;
        end
        chk(hdr == exp_hdr(ap, rd, a) && all_oe, "R1 header", {55'd0, all_oe, hdr}, {56'd1, exp_hdr(ap, rd, a)});
        rel = 1'b1;
        slot(1'b0, 1'b0, o, oe); rel &= !oe;
        for (int i = 0; i < 3; i++) begin slot(1'b1, ack[i], o, oe); rel &= !oe; end
        chk(rel, "R2 turnaround+ack released", rel, 1);
        if (ack == 3'b001 && rd) begin
            for (int i = 0; i < 33; i++) slot(1'b1, (i < 32) ? d[i] : (^d ^ bp), o, oe);
            slot(1'b0, 1'b0, o, oe);
            chk(!oe, "R4 final turnaround released", oe, 0);
        end else if (ack == 3'b001) begin
            slot(1'b0, 1'b0, o, oe);
            chk(!oe, "R5 turnaround before write data", oe, 0);
            all_oe = 1'b1;
            for (int i = 0; i < 32; i++) begin slot(1'b0, 1'b0, o, oe); got[i] = o; all_oe &= oe; end
            slot(1'b0, 1'b0, gp, oe); all_oe &= oe;
            chk(got == d && gp == ^d && all_oe, "R5 write data+parity", {got, 7'd0, all_oe, gp}, {d, 8'd1, ^d});
        end else begin
            slot(1'b0, 1'b0, o, oe);
            chk(!oe, "R3 release after non-OK ack", oe, 0);
        end
        #1;
        chk(done && !busy, "R8 done pulse at end", {done, busy}, 2'b10);
        chk(status == est, "R3/R4 status", status, est);
        if (rd && ack == 3'b001 && !bp) chk(rdata == d, "R4 read data", rdata, d);
        @(posedge clk); #1;
        chk(!done, "R8 done one cycle", done, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        chk(!busy && !swclk && !done && swdio_oe && !swdio_out, "R9 reset state",
            {busy, swclk, done, swdio_oe, swdio_out}, 5'b00010);

        for (int k = 0; k < NV; k++) xact(VEC[k], 1'b0);

        // R8: request during busy ignored, no follow-on access
        xact({1'b1, 1'b0, 2'd2, 3'b010, 1'b0, 32'h0, 3'd1}, 1'b1);
        repeat (20) @(posedge clk); #1;
        chk(!busy && !swclk, "R8 ignored request did not start", {busy, swclk}, 0);

        // R7: slower setting while idle applies now (half = 4)
        @(negedge clk); div_valid = 1'b1; div_val = 8'd3;
        @(negedge clk); div_valid = 1'b0;
        swdio_in = 1'b1;
        issue(1'b0, 1'b1, 2'd0, 32'h0);
        @(swclk); @(swclk); @(swclk); repeat (2) @(posedge clk); #1;
        chk(last_half == 4, "R7 half period div=3", last_half, 4);
        // R7: faster setting mid-access is deferred
        @(negedge clk); div_valid = 1'b1; div_val = 8'd1;
        @(negedge clk); div_valid = 1'b0;
        @(swclk); @(swclk); repeat (2) @(posedge clk); #1;
        chk(last_half == 4, "R7 faster setting deferred", last_half, 4);
        wait (done); @(posedge clk); #1;
        chk(status == 3'd3, "R3 floating line gives protocol error", status, 3);
        issue(1'b0, 1'b1, 2'd0, 32'h0);
        @(swclk); @(swclk); @(swclk); repeat (2) @(posedge clk); #1;
        chk(last_half == 2, "R7 faster setting applied when idle", last_half, 2);
        // R7: slower setting mid-access applies at once
        @(negedge clk); div_valid = 1'b1; div_val = 8'd5;
        @(negedge clk); div_valid = 1'b0;
        @(swclk); @(swclk); repeat (2) @(posedge clk); #1;
        chk(last_half == 6, "R7 slower setting immediate", last_half, 6);
        wait (done); repeat (4) @(posedge clk); #1;
        chk(!busy && !swclk, "R9 idle after access", {busy, swclk}, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule